// File: doc/BRIEF.md
# Set-Less-Than Decode and Execute Unit

This block recognises the four set-on-less-than instructions of a 32-bit load/store instruction set and executes them. One instruction word and two register values go in. The first register value belongs to the source field, and the second to the target field. The block compares the source value against either the target value or the sign-extended 16-bit immediate, using a signed or an unsigned ordering. It produces a result of 1 or 0 together with the destination register index, a write-enable and a flag for words it does not handle.

The surrounding pipeline reads the register file and presents both operand values with the instruction. It takes the result and the write-enable back. A word flagged as not recognised is left to other execute units. The logic is combinational. A parameter can add one register stage on all outputs; this stage is present by default.

Top module: `slt_unit`

## Requirements
- R1: A word whose bits [31:26] are 000000, whose bits [10:6] are 00000 and whose bits [5:0] are 101010 does the following. It sets the result to 1 when the source value is less than the target value, with both read as two's-complement numbers. It sets the destination to bits [15:11] and the source index to bits [25:21].
- R2: With bits [5:0] equal to 101011 and the other conditions of R1 unchanged, the compare is unsigned. The destination is still bits [15:11].
- R3: A word with bits [31:26] equal to 001010 compares the source value against bits [15:0] sign-extended to 32 bits, as signed numbers. The destination is bits [20:16] and the source index is bits [25:21].
- R4: A word with bits [31:26] equal to 001011 sign-extends bits [15:0] in the same way. It then compares the source value and the extended immediate as unsigned numbers.
- R5: For a recognised word the result is 32'h0000_0001 when the compare holds and 32'h0000_0000 when it does not. Bits [31:1] are always zero.
- R6: A word that matches R1 or R2 except that bits [10:6] are nonzero raises the not-recognised flag, and write-enable stays low.
- R7: For any word not covered by R1 to R4, the not-recognised flag is 1. Write-enable, result, destination and source index are all 0.
- R8: For a recognised word whose destination field is 0, write-enable is 0. The result is still presented and the not-recognised flag is 0. For any other recognised word, write-enable is 1.
- R9: With the output stage present, every output shows the response to the inputs one rising clock edge later. While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| instr_i | input | 32 | Instruction word |
| src_val_i | input | 32 | Value of the register named in bits [25:21] |
| tgt_val_i | input | 32 | Value of the register named in bits [20:16] |
| result_o | output | 32 | Compare result, 1 or 0 |
| src_idx_o | output | 5 | Source register index |
| dst_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write request |
| unknown_o | output | 1 | Word is not a set-less-than instruction |

## Verification
With the default output stage, every output is due exactly one rising edge after the instruction and operands are applied. The bench drives new inputs on each falling edge. On the next falling edge it checks the outputs against the expectation it built from the previous inputs, which it holds in a one-entry queue, before it applies the next inputs. The reset values are sampled on a falling edge while reset is held, with a recognised instruction on the inputs, so that a combinational leak would show.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int ILEN    = 32;
  localparam int RIDX_W  = 5;
  localparam int OPC_W   = 6;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REGFORM = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_IMM_S   = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_IMM_U   = 6'b001011;
  localparam logic [5:0]       FN_LT_S     = 6'b101010;
  localparam logic [5:0]       FN_LT_U     = 6'b101011;

  typedef struct packed {
    logic              hit;
    logic              uns;
    logic              use_imm;
    logic [RIDX_W-1:0] src;
    logic [RIDX_W-1:0] dst;
  } slt_dec_t;

  function automatic logic [OPC_W-1:0] f_opcode(input logic [ILEN-1:0] w);
    return w[31:26];
  endfunction

  function automatic logic [RIDX_W-1:0] f_rs(input logic [ILEN-1:0] w);
    return w[25:21];
  endfunction

  function automatic logic [RIDX_W-1:0] f_rt(input logic [ILEN-1:0] w);
    return w[20:16];
  endfunction

  function automatic logic [RIDX_W-1:0] f_rd(input logic [ILEN-1:0] w);
    return w[15:11];
  endfunction

  function automatic logic [4:0] f_shamt(input logic [ILEN-1:0] w);
    return w[10:6];
  endfunction

  function automatic logic [5:0] f_funct(input logic [ILEN-1:0] w);
    return w[5:0];
  endfunction
endpackage

// File: rtl/slt_decode.sv
module slt_decode
  import slt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:0] instr,
  output slt_dec_t        dec,
  output logic [XLEN-1:0] imm_ext
);
  logic [OPC_W-1:0] opc;
  logic             is_regform;
  logic             shamt_zero;
  logic             fn_signed;
  logic             fn_unsigned;
  logic             reg_hit;
  logic             imm_hit;

  assign opc         = f_opcode(instr);
  assign is_regform  = (opc == OPC_REGFORM);
  assign shamt_zero  = (f_shamt(instr) == 5'd0);
  assign fn_signed   = (f_funct(instr) == FN_LT_S);
  assign fn_unsigned = (f_funct(instr) == FN_LT_U);
  assign reg_hit     = is_regform && shamt_zero && (fn_signed || fn_unsigned);
  assign imm_hit     = (opc == OPC_IMM_S) || (opc == OPC_IMM_U);

  assign imm_ext = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  always_comb begin
    dec = '0;
    if (reg_hit) begin
      dec.hit     = 1'b1;
      dec.uns     = fn_unsigned;
      dec.use_imm = 1'b0;
      dec.src     = f_rs(instr);
      dec.dst     = f_rd(instr);
    end else if (imm_hit) begin
      dec.hit     = 1'b1;
      dec.uns     = (opc == OPC_IMM_U);
      dec.use_imm = 1'b1;
      dec.src     = f_rs(instr);
      dec.dst     = f_rt(instr);
    end
  end
endmodule

// File: rtl/slt_compare.sv
module slt_compare #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic            uns,
  output logic            lt
);
  logic            sign_differs;
  logic            mag_lt;

  assign sign_differs = lhs[XLEN-1] ^ rhs[XLEN-1];
  assign mag_lt       = (lhs < rhs);

  always_comb begin
    if (sign_differs)
      lt = uns ? rhs[XLEN-1] : lhs[XLEN-1];
    else
      lt = mag_lt;
  end
endmodule

// File: rtl/slt_outstage.sv
module slt_outstage #(
  parameter int  XLEN    = 32,
  parameter int  RIDX_W  = 5,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   d_res,
  input  logic [RIDX_W-1:0] d_src,
  input  logic [RIDX_W-1:0] d_dst,
  input  logic              d_wen,
  input  logic              d_unk,
  output logic [XLEN-1:0]   q_res,
  output logic [RIDX_W-1:0] q_src,
  output logic [RIDX_W-1:0] q_dst,
  output logic              q_wen,
  output logic              q_unk
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_res <= '0;
          q_src <= '0;
          q_dst <= '0;
          q_wen <= 1'b0;
          q_unk <= 1'b0;
        end else begin
          q_res <= d_res;
          q_src <= d_src;
          q_dst <= d_dst;
          q_wen <= d_wen;
          q_unk <= d_unk;
        end
      end
    end else begin : g_pass
      assign q_res = d_res;
      assign q_src = d_src;
      assign q_dst = d_dst;
      assign q_wen = d_wen;
      assign q_unk = d_unk;
    end
  endgenerate
endmodule

// File: rtl/slt_unit.sv
module slt_unit
  import slt_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ILEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   src_val_i,
  input  logic [XLEN-1:0]   tgt_val_i,
  output logic [XLEN-1:0]   result_o,
  output logic [RIDX_W-1:0] src_idx_o,
  output logic [RIDX_W-1:0] dst_idx_o,
  output logic              wr_en_o,
  output logic              unknown_o
);
  slt_dec_t        dec;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] rhs_sel;
  logic            cmp_lt;
  logic [XLEN-1:0] c_res;
  logic            c_wen;
  logic            c_unk;
  logic            dst_is_zero;

  slt_decode #(.XLEN(XLEN)) u_dec (
    .instr   (instr_i),
    .dec     (dec),
    .imm_ext (imm_ext)
  );

  assign rhs_sel = dec.use_imm ? imm_ext : tgt_val_i;

  slt_compare #(.XLEN(XLEN)) u_cmp (
    .lhs (src_val_i),
    .rhs (rhs_sel),
    .uns (dec.uns),
    .lt  (cmp_lt)
  );

  assign dst_is_zero = (dec.dst == '0);
  assign c_res       = {{(XLEN-1){1'b0}}, dec.hit & cmp_lt};
  assign c_wen       = dec.hit & ~dst_is_zero;
  assign c_unk       = ~dec.hit;

  slt_outstage #(.XLEN(XLEN), .RIDX_W(RIDX_W), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d_res (c_res),
    .d_src (dec.src),
    .d_dst (dec.dst),
    .d_wen (c_wen),
    .d_unk (c_unk),
    .q_res (result_o),
    .q_src (src_idx_o),
    .q_dst (dst_idx_o),
    .q_wen (wr_en_o),
    .q_unk (unknown_o)
  );

  // R1 / R2: register form writes to bits [15:11]
  a_r1_regform_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.hit && !dec.use_imm) |-> (dec.dst == instr_i[15:11]));

  // R3: immediate form writes to bits [20:16]
  a_r3_immform_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.hit && dec.use_imm) |-> (dec.dst == instr_i[20:16]));

  a_r4_imm_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[31:26] == OPC_IMM_U) |-> (dec.hit && dec.uns));

  a_r5_result_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    result_o[XLEN-1:1] == '0);

  a_r6_shamt_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[31:26] == OPC_REGFORM && instr_i[10:6] != 5'd0) |-> !dec.hit);

  a_r7_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    unknown_o |-> (!wr_en_o && result_o == '0 && dst_idx_o == '0 && src_idx_o == '0));

  a_r8_no_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (dst_idx_o != '0 && !unknown_o));
endmodule

// File: tb/tb_slt_unit.sv
module tb_slt_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] va = '0;
  logic [31:0] vb = '0;
  logic [31:0] result;
  logic [4:0]  src_idx, dst_idx;
  logic        wr_en, unknown;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slt_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr),
    .src_val_i (va),
    .tgt_val_i (vb),
    .result_o  (result),
    .src_idx_o (src_idx),
    .dst_idx_o (dst_idx),
    .wr_en_o   (wr_en),
    .unknown_o (unknown)
  );

  typedef struct {
    logic [31:0] res;
    logic [4:0]  src;
    logic [4:0]  dst;
    logic        wen;
    logic        unk;
    string       tag;
  } exp_t;

  exp_t pend[$];

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    exp_t  e;
    int    op  = w[31:26];
    int    fn  = w[5:0];
    logic  ok  = 1'b0;
    logic  u   = 1'b0;
    logic [31:0] rhs = b;
    logic [4:0]  d = 5'd0;
    logic  lt;
    e.tag = "R7";
    if (op == 0 && w[10:6] == 0 && (fn == 42 || fn == 43)) begin
      ok = 1'b1; u = (fn == 43); d = w[15:11];
      e.tag = u ? "R2" : "R1";
    end else if (op == 10 || op == 11) begin
      ok = 1'b1; u = (op == 11); d = w[20:16];
      rhs = w[15] ? (32'hFFFF0000 | w[15:0]) : {16'h0, w[15:0]};
      e.tag = u ? "R4" : "R3";
    end else if (op == 0 && (fn == 42 || fn == 43)) begin
      e.tag = "R6";
    end
    if (u) lt = a < rhs;
    else   lt = (a ^ 32'h8000_0000) < (rhs ^ 32'h8000_0000);
    if (ok && d == 0) e.tag = "R8";
    e.res = (ok && lt) ? 32'd1 : 32'd0;
    e.src = ok ? w[25:21] : 5'd0;
    e.dst = d;
    e.wen = ok && (d != 0);
    e.unk = !ok;
    return e;
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (result !== e.res || src_idx !== e.src || dst_idx !== e.dst ||
        wr_en !== e.wen || unknown !== e.unk) begin
      fails++;
      $display("FAIL %s: got res=%h src=%0d dst=%0d wen=%b unk=%b exp res=%h src=%0d dst=%0d wen=%b unk=%b",
               e.tag, result, src_idx, dst_idx, wr_en, unknown,
               e.res, e.src, e.dst, e.wen, e.unk);
    end
  endtask

  // apply one vector on a falling edge after checking the previous one (R9 latency of one edge)
  task automatic step(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    if (pend.size() > 0) compare(pend.pop_front());
    instr = w; va = a; vb = b;
    pend.push_back(model(w, a, b));
  endtask

  function automatic logic [31:0] corner(input int k);
    case (k % 6)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] rform(input int s, input int t, input int d, input int sh, input int fn);
    return {6'd0, s[4:0], t[4:0], d[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] iform(input int op, input int s, input int t, input logic [15:0] imm);
    return {op[5:0], s[4:0], t[4:0], imm};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: outputs held at zero during reset while a valid word is applied
    instr = rform(3, 4, 5, 0, 42); va = 32'd1; vb = 32'd2;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== '0 || src_idx !== '0 || dst_idx !== '0 || wr_en !== 1'b0 || unknown !== 1'b0) begin
      fails++;
      $display("FAIL R9: got res=%h src=%0d dst=%0d wen=%b unk=%b exp all zero",
               result, src_idx, dst_idx, wr_en, unknown);
    end
    rst_n = 1'b1;

    // R1 signed register form: -1 < 1 holds signed
    step(rform(1, 2, 3, 0, 42), 32'hFFFF_FFFF, 32'd1);
    // R2 unsigned register form: 0xFFFFFFFF < 1 fails unsigned
    step(rform(1, 2, 3, 0, 43), 32'hFFFF_FFFF, 32'd1);
    // R5 equal operands give zero
    step(rform(7, 8, 9, 0, 42), 32'd55, 32'd55);
    // R3 signed immediate: 5 < -1 fails
    step(iform(10, 4, 6, 16'hFFFF), 32'd5, 32'h0);
    // R4 unsigned immediate: 5 < 0xFFFFFFFF holds
    step(iform(11, 4, 6, 16'hFFFF), 32'd5, 32'h0);
    // R4 positive immediate boundary
    step(iform(11, 4, 6, 16'h7FFF), 32'h0000_7FFE, 32'h0);
    // R6 nonzero shift amount rejected
    step(rform(1, 2, 3, 1, 42), 32'd0, 32'd9);
    step(rform(1, 2, 3, 31, 43), 32'd0, 32'd9);
    // R7 wrong function code and other opcodes
    step(rform(1, 2, 3, 0, 41), 32'd0, 32'd9);
    step(iform(8, 1, 2, 16'h0010), 32'd0, 32'd9);
    // R8 destination zero in both forms
    step(rform(1, 2, 0, 0, 42), 32'd0, 32'd9);
    step(iform(10, 1, 0, 16'h0010), 32'd0, 32'd9);

    for (int n = 0; n < NVEC; n++) begin
      int cls = $urandom_range(0, 7);
      int s = $urandom_range(0, 31);
      int t = $urandom_range(0, 31);
      int d = $urandom_range(0, 31);
      logic [15:0] imm = (n % 3 == 0) ? corner(n)[15:0] : 16'($urandom);
      logic [31:0] a = corner($urandom_range(0, 11));
      logic [31:0] b = corner($urandom_range(0, 11));
      logic [31:0] w;
      case (cls)
        0: w = rform(s, t, d, 0, 42);
        1: w = rform(s, t, d, 0, 43);
        2: w = iform(10, s, t, imm);
        3: w = iform(11, s, t, imm);
        4: w = rform(s, t, d, $urandom_range(1, 31), 42 + (n % 2));
        5: w = rform(s, t, d, 0, $urandom_range(0, 41));
        6: w = {6'($urandom_range(12, 63)), 26'($urandom)};
        default: w = (n % 2) ? rform(s, t, 0, 0, 42) : iform(11, s, 0, imm);
      endcase
      step(w, a, b);
    end
    step(32'h0, 32'h0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule